// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a RISC integer unit. Software always addresses 32 architectural registers. Numbers 0 to 7 are globals that every procedure shares. Numbers 8 to 31 form a window of 24 registers, split into outs (8–15), locals (16–23) and ins (24–31). The windows lie in a circular physical array, and neighbouring windows overlap. The ins of window c are the same physical entries as the outs of window c+1, taken modulo the window count.

A current window pointer chooses the active window. A save command, issued on procedure entry, decrements the pointer. The caller's outs then appear as the callee's ins, and the caller's locals and ins are hidden. A restore command increments the pointer and undoes this. Both moves wrap around the ring. An invalid-window mask marks the window that must not be entered. A save or restore that would land on a marked window raises an overflow or underflow trap flag and leaves the pointer where it was. Spilling and filling of windows is left to trap handlers outside this block.

The block has two combinational read ports and one write port that is clocked on the rising edge. Each port translates its architectural number into a physical entry using the current pointer.

Top module: `rwin_regfile`

## Requirements
- R1: Architectural registers 1–7 address the same storage whatever value the window pointer holds.
- R2: Register 0 reads as zero on both read ports, and a write to register 0 has no effect.
- R3: After a save, registers 24–31 of the new window read the values last written to registers 8–15 of the previous window. After a restore, registers 8–15 read what was written to registers 24–31 in the window that was left.
- R4: A save decrements `cwp_o` by one and a restore increments it by one, modulo NWIN (8 by default). The new value is visible after the clock edge.
- R5: When a save would move the pointer onto a window whose mask bit is set, `ovf_trap_o` is 1 in that same cycle and the pointer does not change.
- R6: When a restore would move the pointer onto a window whose mask bit is set, `unf_trap_o` is 1 in that same cycle and the pointer does not change.
- R7: After a synchronous reset (`rst_n` low at a clock edge), `cwp_o` is 0, every register reads 0, and the mask has only window 1 set. So from window 0, six saves succeed, the seventh overflows, and a restore underflows.
- R8: Locals (16–23) belong to one window only. A local written in one window does not appear as a local of a neighbouring window.
- R9: A write issued in the same cycle as a save or restore goes to the window selected by the pointer as it was before the edge.
- R10: A write becomes visible on either read port right after the clock edge, and the two read ports select their registers independently.
- R11: When save and restore are both asserted, only the save acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rs1_i | input | 5 | Architectural register number for read port 1 |
| rs2_i | input | 5 | Architectural register number for read port 2 |
| rd1_o | output | 32 | Read data, port 1 (combinational) |
| rd2_o | output | 32 | Read data, port 2 (combinational) |
| we_i | input | 1 | Write enable |
| rd_i | input | 5 | Architectural register number to write |
| wd_i | input | 32 | Write data |
| save_i | input | 1 | Save command: decrement the window pointer |
| restore_i | input | 1 | Restore command: increment the window pointer |
| cwp_o | output | 3 | Current window pointer |
| ovf_trap_o | output | 1 | Window overflow flag for a save in this cycle |
| unf_trap_o | output | 1 | Window underflow flag for a restore in this cycle |

## Verification
The address translation is driven with writes to outs, locals, ins and globals. Each is then read back after a save, after a restore and with no pointer move. Together these separate correct overlap of ins and outs from a wrong neighbour direction, keep locals private, and keep globals fixed. A write issued together with a save shows whether the old or the new pointer was used. Runs of six and seven saves from window 0, a restore at window 0, and save and restore asserted together probe the trap flags, the wrap of the pointer and the priority between the two commands.

// File: rtl/rwin_pkg.sv
`timescale 1ns/1ps
// Package rwin_pkg
// Shared sizes and the register-group encoding for the windowed register file.
// Assumes the window count is a power of two, so pointer arithmetic wraps naturally.
package rwin_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_WIN   = 8;
    localparam int NUM_GLB   = 8;
    localparam int GRP_SZ    = 8;
    localparam int ARCH_W    = 5;

    // Upper two bits of an architectural register number
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;
endpackage

// File: rtl/rwin_addr_map.sv
`timescale 1ns/1ps
// Module rwin_addr_map
// Translates an architectural register number plus window pointer into an index
// of the unified physical array: globals occupy entries 0..NGLB-1, then window w
// owns 16 entries (outs at +0, locals at +8). The ins of window w are the outs of
// window w+1 modulo NWIN. Purely combinational; assumes NWIN is a power of two.
module rwin_addr_map #(
    parameter int NWIN  = rwin_pkg::NUM_WIN,
    parameter int NGLB  = rwin_pkg::NUM_GLB,
    localparam int CW   = $clog2(NWIN),
    localparam int NPHY = NGLB + 16 * NWIN,
    localparam int PW   = $clog2(NPHY)
) (
    input  logic [4:0]    arch_i,
    input  logic [CW-1:0] cwp_i,
    output logic [PW-1:0] phys_o
);
    import rwin_pkg::*;

    reg_grp_e      grp;
    logic [CW-1:0] win;
    logic [PW-1:0] base;
    logic [PW-1:0] offs;

    // Decode the group and select the owning window and offset inside it
    always_comb begin
        grp  = reg_grp_e'(arch_i[4:3]);
        win  = cwp_i;
        offs = PW'(arch_i[2:0]);
        case (grp)
            GRP_OUT:   begin win = cwp_i;                  end
            GRP_LOCAL: begin win = cwp_i; offs = PW'(arch_i[2:0]) + PW'(8); end
            GRP_IN:    begin win = cwp_i + CW'(1);         end
            default:   begin win = cwp_i;                  end
        endcase
        base = PW'(NGLB) + (PW'(win) << 4);
    end

    // Final physical index: globals map straight through
    always_comb begin
        if (grp == GRP_GLOBAL) phys_o = PW'(arch_i);
        else                   phys_o = base + offs;
    end

    // p_index_in_range_r1: a translated index always lands inside the array
    always_comb begin
        p_index_in_range_r1: assert (int'(phys_o) < NPHY)
            else $error("physical index out of range");
    end
endmodule

// File: rtl/rwin_cwp_ctrl.sv
`timescale 1ns/1ps
// Module rwin_cwp_ctrl
// Owns the current window pointer and the invalid-window mask. A save steps the
// pointer down, a restore steps it up; a step onto a masked window raises the
// matching trap flag (combinational, same cycle) and the pointer holds. Save wins
// when both commands arrive together. Synchronous active-low reset.
module rwin_cwp_ctrl #(
    parameter int NWIN = rwin_pkg::NUM_WIN,
    parameter logic [NWIN-1:0] MASK_RST = NWIN'(2),
    localparam int CW  = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_i,
    input  logic          restore_i,
    output logic [CW-1:0] cwp_o,
    output logic          ovf_o,
    output logic          unf_o
);
    logic [CW-1:0]   cwp_q;
    logic [NWIN-1:0] mask_q;
    logic [CW-1:0]   cwp_dn;
    logic [CW-1:0]   cwp_up;
    logic            do_restore;

    // Neighbour pointers and effective command after priority
    always_comb begin
        cwp_dn     = cwp_q - CW'(1);
        cwp_up     = cwp_q + CW'(1);
        do_restore = restore_i & ~save_i;
    end

    // Trap detection against the invalid-window mask
    always_comb begin
        ovf_o = save_i     & mask_q[cwp_dn];
        unf_o = do_restore & mask_q[cwp_up];
    end

    // Pointer update: move only on a command that does not trap
    always_ff @(posedge clk) begin
        if (!rst_n)                   cwp_q <= '0;
        else if (save_i && !ovf_o)    cwp_q <= cwp_dn;
        else if (do_restore && !unf_o) cwp_q <= cwp_up;
    end

    // Invalid-window mask: set at reset, maintained by outside handlers only
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= MASK_RST;
    end

    assign cwp_o = cwp_q;

    // p_hold_on_ovf_r5: an overflowing save leaves the pointer in place
    p_hold_on_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> $stable(cwp_q));

    // p_hold_on_unf_r6: an underflowing restore leaves the pointer in place
    p_hold_on_unf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> $stable(cwp_q));

    // p_save_step_r4: a clean save decrements the pointer by one
    p_save_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !ovf_o) |=> (cwp_q == $past(cwp_q) - CW'(1)));

    // p_restore_step_r4: a clean restore increments the pointer by one
    p_restore_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && !unf_o) |=> (cwp_q == $past(cwp_q) + CW'(1)));

    // p_one_trap_r11: at most one trap flag per cycle
    p_one_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_o, unf_o}));

    // p_idle_hold_r4: with no command the pointer stays
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_i && !restore_i) |=> $stable(cwp_q));
endmodule

// File: rtl/rwin_storage.sv
`timescale 1ns/1ps
// Module rwin_storage
// Unified physical array: globals followed by the windowed entries. Two
// combinational read ports and one write port clocked on the rising edge.
// Entry 0 is the hardwired zero register: never written, always read as zero.
module rwin_storage #(
    parameter int DW   = rwin_pkg::DATA_W,
    parameter int NPHY = 136,
    localparam int PW  = $clog2(NPHY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ra1_i,
    input  logic [PW-1:0] ra2_i,
    output logic [DW-1:0] rd1_o,
    output logic [DW-1:0] rd2_o,
    input  logic          we_i,
    input  logic [PW-1:0] wa_i,
    input  logic [DW-1:0] wd_i
);
    logic [DW-1:0] mem [NPHY];

    // Clear all entries on reset; otherwise accept writes except to entry 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHY; i++) mem[i] <= '0;
        end else if (we_i && (wa_i != '0)) begin
            mem[wa_i] <= wd_i;
        end
    end

    // Combinational read, with entry 0 forced to zero
    always_comb begin
        rd1_o = (ra1_i == '0) ? '0 : mem[ra1_i];
        rd2_o = (ra2_i == '0) ? '0 : mem[ra2_i];
    end
endmodule

// File: rtl/rwin_regfile.sv
`timescale 1ns/1ps
// Module rwin_regfile
// Top of the windowed integer register file. Three address mappers (two read
// ports, one write port) share the current window pointer; a write uses the
// pointer value held before the edge even when a save or restore lands on the
// same edge. Assumes NWIN is a power of two and at least 2.
module rwin_regfile #(
    parameter int DW   = rwin_pkg::DATA_W,
    parameter int NWIN = rwin_pkg::NUM_WIN,
    parameter int NGLB = rwin_pkg::NUM_GLB,
    localparam int CW   = $clog2(NWIN),
    localparam int NPHY = NGLB + 16 * NWIN,
    localparam int PW   = $clog2(NPHY),
    localparam int NPORT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    rs1_i,
    input  logic [4:0]    rs2_i,
    output logic [DW-1:0] rd1_o,
    output logic [DW-1:0] rd2_o,
    input  logic          we_i,
    input  logic [4:0]    rd_i,
    input  logic [DW-1:0] wd_i,
    input  logic          save_i,
    input  logic          restore_i,
    output logic [CW-1:0] cwp_o,
    output logic          ovf_trap_o,
    output logic          unf_trap_o
);
    logic [CW-1:0] cwp;
    logic [4:0]    arch [NPORT];
    logic [PW-1:0] phys [NPORT];

    // Gather the architectural numbers of all ports for the mapper array
    always_comb begin
        arch[0] = rs1_i;
        arch[1] = rs2_i;
        arch[2] = rd_i;
    end

    rwin_cwp_ctrl #(.NWIN(NWIN)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_i    (save_i),
        .restore_i (restore_i),
        .cwp_o     (cwp),
        .ovf_o     (ovf_trap_o),
        .unf_o     (unf_trap_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwin_addr_map #(.NWIN(NWIN), .NGLB(NGLB)) i_map (
            .arch_i (arch[p]),
            .cwp_i  (cwp),
            .phys_o (phys[p])
        );
    end

    rwin_storage #(.DW(DW), .NPHY(NPHY)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1_i (phys[0]),
        .ra2_i (phys[1]),
        .rd1_o (rd1_o),
        .rd2_o (rd2_o),
        .we_i  (we_i),
        .wa_i  (phys[2]),
        .wd_i  (wd_i)
    );

    assign cwp_o = cwp;

    // p_zero_read_r2: register 0 reads as zero on both ports
    always_comb begin
        if (rst_n) begin
            p_zero_read_r2: assert ((rs1_i != 5'd0 || rd1_o == '0) &&
                                    (rs2_i != 5'd0 || rd2_o == '0))
                else $error("register 0 not zero");
        end
    end

    // p_write_visible_r10: a plain write is readable right after the edge
    p_write_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && rd_i != 5'd0 && !save_i && !restore_i) |=>
        (rs1_i != $past(rd_i) || rd1_o == $past(wd_i)));

    // p_global_fixed_r1: a global keeps its value across a pointer move
    p_global_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && rs2_i < 5'd8 && (save_i || restore_i)) |=>
        (rs2_i != $past(rs2_i) || rd2_o == $past(rd2_o)));
endmodule

// File: tb/test_rwin_regfile.sv
`timescale 1ns/1ps
// Bench for rwin_regfile: vector table walk, then directed reset and corner tests.
module test_rwin_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rs1 = '0, rs2 = '0, rd = '0;
    logic [31:0] rd1, rd2, wd = '0;
    logic        we = 1'b0, sv = 1'b0, rs = 1'b0;
    logic [2:0]  cwp;
    logic        ovf, unf;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    rwin_regfile i_rwin_regfile (
        .clk(clk), .rst_n(rst_n), .rs1_i(rs1), .rs2_i(rs2), .rd1_o(rd1), .rd2_o(rd2),
        .we_i(we), .rd_i(rd), .wd_i(wd), .save_i(sv), .restore_i(rs),
        .cwp_o(cwp), .ovf_trap_o(ovf), .unf_trap_o(unf)
    );

    // Vector: cmd(2: 0 none, 1 save, 2 restore) we(1) wreg(5) wdata(32) rreg(5) exp(32) cwp(3)
    localparam int NV = 10;
    localparam logic [79:0] VEC [NV] = '{
        {2'd0, 1'b1, 5'd8,  32'hA1A1_0008, 5'd8,  32'hA1A1_0008, 3'd0},  // R10
        {2'd0, 1'b1, 5'd16, 32'h1C41_0000, 5'd16, 32'h1C41_0000, 3'd0},  // R10
        {2'd1, 1'b1, 5'd9,  32'h0000_0099, 5'd24, 32'hA1A1_0008, 3'd7},  // R3 R4
        {2'd0, 1'b0, 5'd0,  32'h0,         5'd25, 32'h0000_0099, 3'd7},  // R9
        {2'd0, 1'b0, 5'd0,  32'h0,         5'd16, 32'h0,         3'd7},  // R8
        {2'd0, 1'b1, 5'd3,  32'h6060_0003, 5'd3,  32'h6060_0003, 3'd7},  // R1
        {2'd0, 1'b1, 5'd26, 32'hC0C0_001A, 5'd26, 32'hC0C0_001A, 3'd7},  // R3
        {2'd2, 1'b0, 5'd0,  32'h0,         5'd16, 32'h1C41_0000, 3'd0},  // R8 R4
        {2'd0, 1'b0, 5'd0,  32'h0,         5'd10, 32'hC0C0_001A, 3'd0},  // R3
        {2'd0, 1'b0, 5'd0,  32'h0,         5'd3,  32'h6060_0003, 3'd0}   // R1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock step with the given stimulus, returning at the next falling edge
    task automatic step(input logic s, input logic r, input logic w,
                        input logic [4:0] a, input logic [31:0] d);
        sv = s; rs = r; we = w; rd = a; wd = d;
        @(posedge clk);
        @(negedge clk);
        sv = 1'b0; rs = 1'b0; we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R7: reset state
        check("R7 cwp", 32'(cwp), 32'd0);
        check("R7 flags", {30'd0, ovf, unf}, 32'd0);
        rs1 = 5'd8; #1 check("R7 regs clear", rd1, 32'd0);
        @(negedge clk);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [79:0] v;
            v = VEC[i];
            step(v[79:78] == 2'd1, v[79:78] == 2'd2, v[77], v[76:72], v[71:40]);
            rs1 = v[39:35];
            #1;
            check($sformatf("R3/R10 vec %0d data", i), rd1, v[34:3]);
            check($sformatf("R4 vec %0d cwp", i), 32'(cwp), 32'(v[2:0]));
        end

        // R2: register 0 writes ignored, reads zero on both ports
        step(1'b0, 1'b0, 1'b1, 5'd0, 32'hDEAD_BEEF);
        rs1 = 5'd0; rs2 = 5'd0; #1;
        check("R2 port1", rd1, 32'd0);
        check("R2 port2", rd2, 32'd0);

        // R10: two ports read independently
        rs1 = 5'd3; rs2 = 5'd10; #1;
        check("R10 port1", rd1, 32'h6060_0003);
        check("R10 port2", rd2, 32'hC0C0_001A);

        // R6: restore at window 0 underflows, pointer holds
        rs = 1'b1; #1;
        check("R6 unf flag", 32'(unf), 32'd1);
        check("R6 no ovf", 32'(ovf), 32'd0);
        @(posedge clk); @(negedge clk); rs = 1'b0; #1;
        check("R6 cwp held", 32'(cwp), 32'd0);

        // R11: save and restore together act as a save
        step(1'b1, 1'b1, 1'b0, 5'd0, 32'd0); #1;
        check("R11 save wins", 32'(cwp), 32'd7);

        // R5 R7: five more saves reach window 2, the next overflows
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b0, 5'd0, 32'd0);
        #1 check("R7 six saves", 32'(cwp), 32'd2);
        sv = 1'b1; #1;
        check("R5 ovf flag", 32'(ovf), 32'd1);
        @(posedge clk); @(negedge clk); sv = 1'b0; #1;
        check("R5 cwp held", 32'(cwp), 32'd2);

        // R4: restores walk back and wrap 7 -> 0
        for (int k = 0; k < 6; k++) step(1'b0, 1'b1, 1'b0, 5'd0, 32'd0);
        #1 check("R4 wrap back", 32'(cwp), 32'd0);
        rs1 = 5'd8; #1 check("R1/R3 window 0 outs kept", rd1, 32'hA1A1_0008);

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule